// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of every beat of one read or write burst in a synchronous DRAM controller or memory model. A start strobe captures the starting column, a burst length code and an order bit. From then on, each cycle with the advance strobe high steps the burst on by one beat. The current column comes out with a valid flag, and a last-beat flag marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 and 8 beats run in one of two orders. In sequential order the low bits count upward and wrap inside the aligned block. In interleaved order the low bits are the start bits XOR the beat index. A sequential full-page mode walks the whole row, wrapping at the row end, until a stop strobe ends it. Any burst can be cut short by the stop strobe.

Some settings are illegal: a reserved length code, full page with interleaved order, or full page with an odd start column. Such a setting is reported on an error flag and starts nothing. Data capture, command decoding and strobe timing are handled by neighbouring blocks.

Top module: `bcag_top`

## Requirements
- R1: The length code `len_code_i` selects the burst: 3'b001 gives 2 beats, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. Codes 3'b000, 3'b100, 3'b101 and 3'b110 are reserved. `order_i` = 0 selects sequential order and 1 selects interleaved order.
- R2: In a sequential fixed burst of length BL starting at column S, beat k outputs the column whose low log2(BL) bits are (S + k) mod BL. The upper bits are equal to those of S (for example BL 8 from 8'hA5 gives A5,A6,A7,A0,A1,A2,A3,A4).
- R3: In an interleaved fixed burst, beat k outputs the column whose low log2(BL) bits are S XOR k. The upper bits are equal to those of S (for example BL 8 from 8'h75 gives 75,74,77,76,71,70,73,72).
- R4: The cycle after a legal start, `valid_o` is 1 and `col_o` equals the start column (beat 0). Each cycle with `advance_i` high moves to the next beat in the following cycle. With `advance_i` low, `col_o` and `last_o` hold.
- R5: `last_o` is 1 only on beat BL-1 of a fixed burst. An advance on that beat makes `valid_o` 0 in the next cycle, unless a start arrives in the same cycle; in that case the new burst's beat 0 follows directly.
- R6: A full-page burst (legal only in sequential order from an even column) outputs (S + k) mod 2^COL_W on beat k. It never raises `last_o` and runs until stopped.
- R7: `stop_i` high during a burst makes `valid_o` 0 in the next cycle, whatever the burst type or beat. A start in the same cycle takes priority and begins a new burst.
- R8: A start with an illegal setting sets `err_o` to 1 for exactly the next cycle. It starts no burst and leaves a burst in progress unchanged. `err_o` is 0 in all other cycles.
- R9: Column, length and order are captured at the start. Changing those inputs during a burst has no effect. A legal start during a burst abandons the old burst and begins the new one at beat 0.
- R10: After reset `valid_o`, `last_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the settings on the inputs below |
| col_start_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| advance_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column of the current beat, meaningful while valid_o is 1 |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |
| err_o | output | 1 | Previous cycle carried a start with an illegal setting |

## Verification
The bound checker watches every cycle for the following:
- a legal start loading beat 0 with the start column;
- the column and last flag holding when no advance arrives;
- a burst ending after its last beat or after a stop;
- the error pulse following exactly the illegal starts;
- an illegal start never opening or disturbing a burst.

The actual column orderings can only be shown by the bench's directed scenarios. These cover sequential and interleaved wrapping for each length, the full-page wrap past the row end, and upper-bit retention. They also cover back-to-back bursts, restarts in mid-burst, and inputs changed during a burst.

// File: rtl/bcag_pkg.sv
`timescale 1ns/1ps
package bcag_pkg;

   // widest fixed burst is 2**FIXED_LOG_MAX beats
   localparam int unsigned FIXED_LOG_MAX = 3;
   localparam int unsigned LEN_CODE_W    = 3;

   localparam logic [LEN_CODE_W-1:0] LEN_BEAT2 = 3'b001;
   localparam logic [LEN_CODE_W-1:0] LEN_BEAT4 = 3'b010;
   localparam logic [LEN_CODE_W-1:0] LEN_BEAT8 = 3'b011;
   localparam logic [LEN_CODE_W-1:0] LEN_PAGE  = 3'b111;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIXED = 2'd1,
      ST_PAGE  = 2'd2
   } burst_state_e;

   typedef struct packed {
      logic       known;
      logic       full_page;
      logic [1:0] log2_len;
   } len_info_t;

   function automatic len_info_t decode_len(input logic [LEN_CODE_W-1:0] code);
      len_info_t r;
      r = '0;
      case (code)
         LEN_BEAT2: begin r.known = 1'b1; r.log2_len = 2'd1; end
         LEN_BEAT4: begin r.known = 1'b1; r.log2_len = 2'd2; end
         LEN_BEAT8: begin r.known = 1'b1; r.log2_len = 2'd3; end
         LEN_PAGE:  begin r.known = 1'b1; r.full_page = 1'b1; end
         default:   r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bcag_cfg_check.sv
`timescale 1ns/1ps
module bcag_cfg_check
   import bcag_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [LEN_CODE_W-1:0]    len_code_i,
   input  logic                     order_i,
   input  logic                     col_lsb_i,
   output logic                     legal_o,
   output logic                     full_page_o,
   output logic [FIXED_LOG_MAX-1:0] mask_o
);

   len_info_t info;

   always_comb begin
      info        = decode_len(len_code_i);
      full_page_o = info.full_page;
      // full page needs sequential order and an even start
      legal_o     = info.known & ~(info.full_page & (order_i | col_lsb_i));
      mask_o      = '0;
      for (int i = 0; i < int'(FIXED_LOG_MAX); i++) begin
         if (i < int'(info.log2_len)) mask_o[i] = 1'b1;
      end
   end

endmodule

// File: rtl/bcag_seq_ctrl.sv
`timescale 1ns/1ps
module bcag_seq_ctrl
   import bcag_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     legal_i,
   input  logic                     full_page_i,
   input  logic [FIXED_LOG_MAX-1:0] mask_i,
   input  logic                     order_i,
   input  logic [COL_W-1:0]         col_start_i,
   input  logic                     advance_i,
   input  logic                     stop_i,
   output logic [COL_W-1:0]         base_o,
   output logic [COL_W-1:0]         beat_o,
   output logic [FIXED_LOG_MAX-1:0] mask_o,
   output logic                     ilv_o,
   output logic                     page_o,
   output logic                     valid_o,
   output logic                     last_o,
   output logic                     err_o
);

   localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);
   localparam int unsigned      PAD_W    = COL_W - FIXED_LOG_MAX;

   burst_state_e             state_q;
   logic [COL_W-1:0]         beat_q;
   logic [COL_W-1:0]         base_q;
   logic [FIXED_LOG_MAX-1:0] mask_q;
   logic                     ilv_q;
   logic                     err_q;
   logic                     at_last;
   logic                     take_start;

   assign take_start = start_i & legal_i;
   assign at_last    = (state_q == ST_FIXED) && (beat_q == {{PAD_W{1'b0}}, mask_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         base_q  <= '0;
         mask_q  <= '0;
         ilv_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q <= start_i & ~legal_i;
         if (take_start) begin
            state_q <= full_page_i ? ST_PAGE : ST_FIXED;
            beat_q  <= '0;
            base_q  <= col_start_i;
            mask_q  <= mask_i;
            ilv_q   <= order_i;
         end else if (state_q != ST_IDLE) begin
            if (stop_i) begin
               state_q <= ST_IDLE;
            end else if (advance_i) begin
               if (at_last) state_q <= ST_IDLE;
               beat_q <= beat_q + BEAT_ONE;
            end
         end
      end
   end

   assign base_o  = base_q;
   assign beat_o  = beat_q;
   assign mask_o  = mask_q;
   assign ilv_o   = ilv_q;
   assign page_o  = (state_q == ST_PAGE);
   assign valid_o = (state_q != ST_IDLE);
   assign last_o  = at_last;
   assign err_o   = err_q;

endmodule

// File: rtl/bcag_addr_map.sv
`timescale 1ns/1ps
module bcag_addr_map
   import bcag_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0]         base_i,
   input  logic [COL_W-1:0]         beat_i,
   input  logic [FIXED_LOG_MAX-1:0] mask_i,
   input  logic                     interleave_i,
   input  logic                     page_i,
   output logic [COL_W-1:0]         col_o
);

   logic [COL_W-1:0] seq_sum;

   // carries out of the masked field are discarded by the per-bit select
   assign seq_sum = base_i + beat_i;

   for (genvar b = 0; b < int'(COL_W); b++) begin : g_bit
      if (b < int'(FIXED_LOG_MAX)) begin : g_low
         logic fixed_bit;
         assign fixed_bit = !mask_i[b]   ? base_i[b] :
                            interleave_i ? (base_i[b] ^ beat_i[b]) :
                                           seq_sum[b];
         assign col_o[b]  = page_i ? seq_sum[b] : fixed_bit;
      end else begin : g_high
         assign col_o[b]  = page_i ? seq_sum[b] : base_i[b];
      end
   end

endmodule

// File: rtl/bcag_top.sv
`timescale 1ns/1ps
module bcag_top
   import bcag_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [COL_W-1:0]      col_start_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  order_i,
   input  logic                  advance_i,
   input  logic                  stop_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o,
   output logic                  err_o
);

   initial begin
      assert (COL_W > FIXED_LOG_MAX)
         else $fatal(1, "bcag_top: COL_W must exceed the widest fixed burst field");
   end

   logic                     cfg_legal;
   logic                     cfg_page;
   logic [FIXED_LOG_MAX-1:0] cfg_mask;
   logic [COL_W-1:0]         cur_base;
   logic [COL_W-1:0]         cur_beat;
   logic [FIXED_LOG_MAX-1:0] cur_mask;
   logic                     cur_ilv;
   logic                     cur_page;

   bcag_cfg_check #(.COL_W(COL_W)) cfg_u (
      .len_code_i  (len_code_i),
      .order_i     (order_i),
      .col_lsb_i   (col_start_i[0]),
      .legal_o     (cfg_legal),
      .full_page_o (cfg_page),
      .mask_o      (cfg_mask)
   );

   bcag_seq_ctrl #(.COL_W(COL_W)) ctrl_u (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .legal_i     (cfg_legal),
      .full_page_i (cfg_page),
      .mask_i      (cfg_mask),
      .order_i     (order_i),
      .col_start_i (col_start_i),
      .advance_i   (advance_i),
      .stop_i      (stop_i),
      .base_o      (cur_base),
      .beat_o      (cur_beat),
      .mask_o      (cur_mask),
      .ilv_o       (cur_ilv),
      .page_o      (cur_page),
      .valid_o     (valid_o),
      .last_o      (last_o),
      .err_o       (err_o)
   );

   bcag_addr_map #(.COL_W(COL_W)) map_u (
      .base_i       (cur_base),
      .beat_i       (cur_beat),
      .mask_i       (cur_mask),
      .interleave_i (cur_ilv),
      .page_i       (cur_page),
      .col_o        (col_o)
   );

endmodule

// File: rtl/bcag_chk.sv
`timescale 1ns/1ps
module bcag_chk
   import bcag_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_i,
   input logic [COL_W-1:0]      col_start_i,
   input logic [LEN_CODE_W-1:0] len_code_i,
   input logic                  order_i,
   input logic                  advance_i,
   input logic                  stop_i,
   input logic [COL_W-1:0]      col_o,
   input logic                  valid_o,
   input logic                  last_o,
   input logic                  err_o
);

   logic code_reserved;
   logic cfg_bad;

   assign code_reserved = (len_code_i != 3'b001) && (len_code_i != 3'b010) &&
                          (len_code_i != 3'b011) && (len_code_i != 3'b111);
   assign cfg_bad = code_reserved || ((len_code_i == 3'b111) && (order_i || col_start_i[0]));

   // R8
   bad_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && cfg_bad |=> err_o);

   // R8
   err_only_after_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_i && cfg_bad) |=> !err_o);

   // R8
   bad_start_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && cfg_bad && !valid_o |=> !valid_o);

   // R8
   bad_start_no_disturb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && cfg_bad && valid_o && !advance_i && !stop_i |=> valid_o && $stable(col_o));

   // R4
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !cfg_bad |=> valid_o && (col_o == $past(col_start_i)) && !last_o);

   // R4
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !start_i && !advance_i && !stop_i |=> valid_o && $stable(col_o) && $stable(last_o));

   // R5
   last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && last_o && advance_i && !start_i |=> !valid_o);

   // R5
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R7
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && stop_i && !start_i |=> !valid_o);

   // R10
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o && !start_i |=> !valid_o);

endmodule

bind bcag_top bcag_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/bcag_top_tb_top.sv
`timescale 1ns/1ps
module bcag_top_tb_top;

   localparam int unsigned COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] col_start_i = '0;
   logic [2:0]       len_code_i = 3'b000;
   logic             order_i = 1'b0;
   logic             advance_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;
   logic             err_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   bcag_top #(.COL_W(COL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_start_i(col_start_i),
      .len_code_i(len_code_i), .order_i(order_i), .advance_i(advance_i),
      .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
      .err_o(err_o)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_col(input logic [7:0] s, input int bl,
                                          input bit ilv, input int k);
      logic [7:0] m, low, kk;
      kk = k[7:0];
      if (bl == 256) return s + kk;
      m   = bl[7:0] - 8'd1;
      low = ilv ? (s ^ kk) : (s + kk);
      return (s & ~m) | (low & m);
   endfunction

   task automatic issue_start(input logic [7:0] s, input logic [2:0] code, input bit ilv);
      start_i = 1'b1; col_start_i = s; len_code_i = code; order_i = ilv;
      step();
      start_i = 1'b0;
   endtask

   // full fixed burst; settings inputs are scrambled after the start (R9)
   task automatic run_fixed(input string req, input logic [7:0] s,
                            input logic [2:0] code, input bit ilv, input int bl);
      issue_start(s, code, ilv);
      col_start_i = ~s; len_code_i = 3'b111; order_i = ~ilv;
      for (int k = 0; k < bl; k++) begin
         chk(req, "beat valid", valid_o, 1);
         chk(req, "beat column", col_o, exp_col(s, bl, ilv, k));
         chk("R5", "last flag", last_o, (k == bl - 1));
         advance_i = 1'b1;
         step();
      end
      advance_i = 1'b0;
      chk("R5", "idle after last", valid_o, 0);
   endtask

   task automatic t_reset();
      chk("R10", "valid in reset", valid_o, 0);
      chk("R10", "last in reset", last_o, 0);
      chk("R10", "err in reset", err_o, 0);
      rst_n = 1'b1;
      step();
      chk("R10", "valid after reset", valid_o, 0);
      chk("R10", "err after reset", err_o, 0);
   endtask

   task automatic t_sequential();
      run_fixed("R2", 8'hA5, 3'b011, 1'b0, 8);
      run_fixed("R2", 8'h3E, 3'b010, 1'b0, 4);
      run_fixed("R1", 8'h81, 3'b001, 1'b0, 2);
   endtask

   task automatic t_interleave();
      run_fixed("R3", 8'h75, 3'b011, 1'b1, 8);
      run_fixed("R3", 8'h32, 3'b010, 1'b1, 4);
      run_fixed("R1", 8'h01, 3'b001, 1'b1, 2);
   endtask

   task automatic t_full_page();
      issue_start(8'hFC, 3'b111, 1'b0);
      for (int k = 0; k < 6; k++) begin
         chk("R6", "page valid", valid_o, 1);
         chk("R6", "page column", col_o, exp_col(8'hFC, 256, 1'b0, k));
         chk("R6", "page last", last_o, 0);
         advance_i = 1'b1;
         step();
      end
      chk("R6", "page column after wrap", col_o, 8'h02);
      advance_i = 1'b0; stop_i = 1'b1;
      step();
      stop_i = 1'b0;
      chk("R7", "page stopped", valid_o, 0);
   endtask

   task automatic t_illegal();
      logic [7:0] cols  [6] = '{8'h10, 8'h11, 8'h20, 8'h20, 8'h20, 8'h20};
      logic [2:0] codes [6] = '{3'b111, 3'b111, 3'b000, 3'b100, 3'b101, 3'b110};
      bit         ords  [6] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      for (int i = 0; i < 6; i++) begin
         issue_start(cols[i], codes[i], ords[i]);
         chk("R8", "err after illegal", err_o, 1);
         chk("R8", "no burst on illegal", valid_o, 0);
         step();
         chk("R8", "err one cycle", err_o, 0);
         chk("R8", "still idle", valid_o, 0);
      end
   endtask

   task automatic t_illegal_mid();
      issue_start(8'h20, 3'b010, 1'b0);
      advance_i = 1'b1;
      step();
      advance_i = 1'b0;
      chk("R4", "advanced column", col_o, 8'h21);
      issue_start(8'h60, 3'b111, 1'b1);
      chk("R8", "err mid burst", err_o, 1);
      chk("R8", "burst kept", valid_o, 1);
      chk("R8", "column kept", col_o, 8'h21);
      advance_i = 1'b1;
      step();
      chk("R8", "burst continues", col_o, 8'h22);
      step();
      chk("R8", "burst continues", col_o, 8'h23);
      chk("R5", "last of kept burst", last_o, 1);
      step();
      advance_i = 1'b0;
      chk("R5", "kept burst ended", valid_o, 0);
   endtask

   task automatic t_stop();
      issue_start(8'h40, 3'b011, 1'b0);
      advance_i = 1'b1;
      step(); step();
      chk("R4", "column before stop", col_o, 8'h42);
      stop_i = 1'b1;
      step();
      stop_i = 1'b0; advance_i = 1'b0;
      chk("R7", "fixed burst stopped", valid_o, 0);
      step();
      chk("R7", "stays stopped", valid_o, 0);
      issue_start(8'h30, 3'b010, 1'b0);
      stop_i = 1'b1;
      issue_start(8'h44, 3'b001, 1'b0);
      stop_i = 1'b0;
      chk("R7", "start beats stop", valid_o, 1);
      chk("R7", "start beats stop column", col_o, 8'h44);
      advance_i = 1'b1;
      step(); step();
      advance_i = 1'b0;
      chk("R5", "short burst ended", valid_o, 0);
   endtask

   task automatic t_hold();
      issue_start(8'h13, 3'b010, 1'b1);
      for (int i = 0; i < 3; i++) begin
         chk("R4", "hold column", col_o, 8'h13);
         step();
      end
      advance_i = 1'b1;
      step();
      chk("R4", "step after hold", col_o, 8'h12);
      stop_i = 1'b1;
      step();
      stop_i = 1'b0; advance_i = 1'b0;
      chk("R7", "stopped after hold", valid_o, 0);
   endtask

   task automatic t_back_to_back();
      issue_start(8'h06, 3'b001, 1'b0);
      advance_i = 1'b1;
      step();
      chk("R5", "first burst last", last_o, 1);
      chk("R2", "first burst beat 1", col_o, 8'h07);
      issue_start(8'h09, 3'b010, 1'b1);
      chk("R5", "chained valid", valid_o, 1);
      chk("R5", "chained beat 0", col_o, 8'h09);
      chk("R5", "chained not last", last_o, 0);
      step();
      chk("R3", "chained beat 1", col_o, 8'h08);
      step();
      chk("R3", "chained beat 2", col_o, 8'h0B);
      step();
      chk("R3", "chained beat 3", col_o, 8'h0A);
      chk("R5", "chained last", last_o, 1);
      step();
      advance_i = 1'b0;
      chk("R5", "chained ended", valid_o, 0);
   endtask

   task automatic t_restart();
      issue_start(8'h50, 3'b011, 1'b0);
      advance_i = 1'b1;
      step(); step();
      chk("R4", "before restart", col_o, 8'h52);
      issue_start(8'h71, 3'b001, 1'b0);
      chk("R9", "restart beat 0", col_o, 8'h71);
      chk("R9", "restart not last", last_o, 0);
      step();
      chk("R9", "restart beat 1", col_o, 8'h70);
      chk("R9", "restart last", last_o, 1);
      step();
      advance_i = 1'b0;
      chk("R9", "restart ended", valid_o, 0);
   endtask

   initial begin
      step(); step();
      t_reset();
      t_sequential();
      t_interleave();
      t_full_page();
      t_illegal();
      t_illegal_mid();
      t_stop();
      t_hold();
      t_back_to_back();
      t_restart();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule